// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is a byte-wide memory that answers as a slave on a two-wire serial bus. It samples the clock line and the data line through synchronizers and pulls the data line low through one open-drain enable. A transfer opens with a start condition followed by an address byte. That byte carries a fixed 4-bit device code, two select bits that must equal a pair of strap inputs, the top bit of the memory address, and a direction bit. The memory is a plain register array of 2^ADDR_W bytes, 512 with the default parameters. The slave keeps one address counter. Every byte read or written advances it by one, and it wraps from the top of the array back to zero.

Reads come in three kinds. A current-address read returns data from the counter. A random read first writes a word address, then issues a repeated start and a read-direction address byte. A sequential read continues either kind for as long as the master acknowledges each byte. If the master sends a stop where the repeated start would go, the word address is loaded into the counter and no data moves. A single-byte write is also supported, so memory contents can be preset over the bus.

The controller is one state machine with these states:
- ST_IDLE: standby.
- ST_ADDR: receiving the address byte.
- ST_ADDR_ACK: acknowledging the address byte.
- ST_WORD and ST_WORD_ACK: receiving and acknowledging the word address.
- ST_WDATA and ST_WDATA_ACK: receiving and acknowledging the data byte.
- ST_RDATA: shifting out a byte.
- ST_RACK: sampling the master's acknowledge.

Its transitions are:
- A start condition moves any state to ST_ADDR.
- A stop condition moves any state to ST_IDLE.
- ST_ADDR goes to ST_ADDR_ACK on a match, and to ST_IDLE otherwise.
- ST_ADDR_ACK goes to ST_RDATA when the direction bit is 1, and to ST_WORD when it is 0.
- ST_WORD goes to ST_WORD_ACK, then to ST_WDATA.
- ST_WDATA goes to ST_WDATA_ACK, then to ST_IDLE.
- ST_RDATA goes to ST_RACK.
- ST_RACK goes back to ST_RDATA when the master acknowledges, and to ST_IDLE when it does not.

Top module: `i2c_mem_slave`

## Requirements
- R1: After reset the slave is in standby with the data line released (sda_pull_o = 0).
- R2: An address byte matches when bits 7..4 equal 4'b1010 and bits 3..2 equal sel_i. On a match the slave pulls SDA low for the ninth clock. Bit 0 set to 1 selects read and 0 selects write. Bit 1 is the top address bit in write direction and is ignored in read direction.
- R3: On a non-matching address byte the slave does not acknowledge. It then ignores every following byte (no ACK, no memory or counter change) until the next start.
- R4: A random read returns the byte at the loaded address. The loaded address is formed from bit 1 of the write-direction address byte as the top bit and the low ADDR_W-1 bits of the word-address byte below it. The upper bits of the word-address byte are ignored.
- R5: A stop right after the word-address acknowledge loads the counter without moving data. The next current-address read returns the byte at that address.
- R6: A current-address read returns the byte at the counter. The counter always points one past the last byte read or written.
- R7: Each byte acknowledged by the master is followed by the byte at the next address. Bytes are sent most significant bit first.
- R8: The read counter wraps from address 2^ADDR_W-1 to 0 and data continues.
- R9: After a master no-acknowledge the slave releases SDA. After a stop it ignores bus clocking until a start.
- R10: In a write, exactly one data byte is stored at the loaded address and acknowledged. Further bytes in the same transfer are not acknowledged and not stored.
- R11: The slave changes sda_pull_o only while SCL is low.
- R12: A start condition in the middle of any byte abandons it and restarts address-byte reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sel_i | input | 2 | Strap value that the select bits must match |
| sda_pull_o | output | 1 | When 1, the slave pulls the data line low |

## Verification
The bench builds the block with ADDR_W = 5 and sel_i = 2'b10. This gives a 32-byte array, so every location can be written and then read back by random read, with a follow-up current-address read. The small array also puts the counter wrap within a single sequential read of 40 bytes, and lets the word byte's unused upper bits carry junk to show they are ignored. Expected bytes come from an arithmetic pattern per address, with the few overwritten locations tracked alongside.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WORD,
        ST_WORD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } slv_state_t;

    localparam logic [3:0] DEV_CODE_DEFAULT = 4'b1010;

endpackage

// File: rtl/i2c_bus_sense.sv
module i2c_bus_sense #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic [SYNC_STAGES-1:0] scl_ff;
    logic [SYNC_STAGES-1:0] sda_ff;
    logic                   scl_prev;
    logic                   sda_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff   <= '1;
            sda_ff   <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_ff   <= {scl_ff[SYNC_STAGES-2:0], scl_i};
            sda_ff   <= {sda_ff[SYNC_STAGES-2:0], sda_i};
            scl_prev <= scl_ff[SYNC_STAGES-1];
            sda_prev <= sda_ff[SYNC_STAGES-1];
        end
    end

    assign scl_o      = scl_ff[SYNC_STAGES-1];
    assign sda_o      = sda_ff[SYNC_STAGES-1];
    assign scl_rise_o = scl_o & ~scl_prev;
    assign scl_fall_o = ~scl_o & scl_prev;
    assign start_o    = scl_o & scl_prev & sda_prev & ~sda_o;
    assign stop_o     = scl_o & scl_prev & ~sda_prev & sda_o;

endmodule

// File: rtl/i2c_mem_array.sv
module i2c_mem_array #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            cells[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = cells[raddr_i];

endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
    import i2c_mem_pkg::*;
#(
    parameter int         ADDR_W   = 9,
    parameter logic [3:0] DEV_CODE = DEV_CODE_DEFAULT
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [1:0] sel_i,
    output logic       sda_pull_o
);

    localparam int LOW_W = ADDR_W - 1;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    slv_state_t        state, state_nx;
    logic [3:0]        bit_cnt;
    logic [7:0]        shreg;
    logic [7:0]        txreg;
    logic [ADDR_W-1:0] ptr;
    logic              msb_q;
    logic              mack_q;
    logic              pull_q;
    logic [7:0]        rd_data;
    logic              mem_we;
    logic              byte_done;
    logic              addr_hit;

    i2c_bus_sense #(.SYNC_STAGES(2)) sense_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    i2c_mem_array #(.ADDR_W(ADDR_W), .DATA_W(8)) array_i (
        .clk     (clk),
        .we_i    (mem_we),
        .waddr_i (ptr),
        .wdata_i (shreg),
        .raddr_i (ptr),
        .rdata_o (rd_data)
    );

    assign byte_done = (bit_cnt == 4'd8);
    assign addr_hit  = (shreg[7:4] == DEV_CODE) && (shreg[3:2] == sel_i);
    assign mem_we    = (state == ST_WDATA) && scl_fall && byte_done;

    // next-state logic
    always_comb begin
        state_nx = state;
        if (start_det) begin
            state_nx = ST_ADDR;
        end else if (stop_det) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:      state_nx = ST_IDLE;
                ST_ADDR:      if (scl_fall && byte_done) state_nx = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK:  if (scl_fall) state_nx = shreg[0] ? ST_RDATA : ST_WORD;
                ST_WORD:      if (scl_fall && byte_done) state_nx = ST_WORD_ACK;
                ST_WORD_ACK:  if (scl_fall) state_nx = ST_WDATA;
                ST_WDATA:     if (scl_fall && byte_done) state_nx = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) state_nx = ST_IDLE;
                ST_RDATA:     if (scl_fall && byte_done) state_nx = ST_RACK;
                ST_RACK:      if (scl_fall) state_nx = mack_q ? ST_RDATA : ST_IDLE;
                default:      state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath and output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            txreg   <= '0;
            ptr     <= '0;
            msb_q   <= 1'b0;
            mack_q  <= 1'b0;
            pull_q  <= 1'b0;
        end else if (start_det || stop_det) begin
            bit_cnt <= '0;
            pull_q  <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR, ST_WORD, ST_WDATA: begin
                    if (scl_rise && !byte_done) begin
                        shreg   <= {shreg[6:0], sda_s};
                        bit_cnt <= bit_cnt + 4'd1;
                    end
                    if (scl_fall && byte_done) begin
                        bit_cnt <= '0;
                        pull_q  <= (state != ST_ADDR) || addr_hit;
                        if (state == ST_ADDR)  msb_q <= shreg[1];
                        if (state == ST_WORD)  ptr   <= {msb_q, shreg[LOW_W-1:0]};
                        if (state == ST_WDATA) ptr   <= ptr + 1'b1;
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        if (shreg[0]) begin
                            txreg  <= rd_data;
                            pull_q <= ~rd_data[7];
                            ptr    <= ptr + 1'b1;
                        end else begin
                            pull_q <= 1'b0;
                        end
                    end
                end
                ST_WORD_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) pull_q <= 1'b0;
                end
                ST_RDATA: begin
                    if (scl_rise) bit_cnt <= bit_cnt + 4'd1;
                    if (scl_fall) begin
                        if (byte_done) begin
                            pull_q  <= 1'b0;
                            bit_cnt <= '0;
                        end else begin
                            txreg  <= {txreg[6:0], 1'b0};
                            pull_q <= ~txreg[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) mack_q <= ~sda_s;
                    if (scl_fall) begin
                        if (mack_q) begin
                            txreg  <= rd_data;
                            pull_q <= ~rd_data[7];
                            ptr    <= ptr + 1'b1;
                        end else begin
                            pull_q <= 1'b0;
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    assign sda_pull_o = pull_q;

    AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull_o != $past(sda_pull_o)) |-> !$past(scl_s)); // R11

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_pull_o); // R9

    AST_START_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_ADDR && bit_cnt == 4'd0 && !sda_pull_o)); // R12

    AST_NO_ACK_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && scl_fall && byte_done && !addr_hit) |=> (state == ST_IDLE && !sda_pull_o)); // R3

    AST_READ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RACK && scl_fall && mack_q) |=> (ptr == ADDR_W'($past(ptr) + 1'b1))); // R8

endmodule

// File: tb/i2c_mem_slave_tb_top.sv
module i2c_mem_slave_tb_top;

    localparam int         AW    = 5;
    localparam int         DEPTH = 1 << AW;
    localparam int         Q     = 5;
    localparam logic [1:0] SEL   = 2'b10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull;
    logic sda_line;

    int n_cmp = 0;
    int n_err = 0;
    int r11_viol = 0;
    bit done = 1'b0;

    logic [7:0] model [DEPTH];

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;

    i2c_mem_slave #(.ADDR_W(AW)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sel_i      (SEL),
        .sda_pull_o (sda_pull)
    );

    // R11 monitor: output may only move while SCL is low
    logic pull_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && (sda_pull != pull_prev) && scl_m) r11_viol++;
        pull_prev <= sda_pull;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(1);
        scl_m = 1'b1; wq(1);
        sda_m = 1'b0; wq(1);
        scl_m = 1'b0; wq(1);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(1);
        scl_m = 1'b1; wq(1);
        sda_m = 1'b1; wq(1);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; wq(1);
            scl_m = 1'b1; wq(2);
            scl_m = 1'b0; wq(1);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1'b1; wq(1);
        scl_m = 1'b1; wq(1);
        ack = ~sda_line; wq(1);
        scl_m = 1'b0; wq(1);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; wq(1);
            scl_m = 1'b1; wq(1);
            b[i] = sda_line; wq(1);
            scl_m = 1'b0; wq(1);
        end
        sda_m = ~mack; wq(1);
        scl_m = 1'b1; wq(2);
        scl_m = 1'b0; wq(1);
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] abyte(input logic rw, input logic msb);
        return {4'b1010, SEL, msb, rw};
    endfunction

    function automatic logic [7:0] wbyte(input logic [AW-1:0] a);
        return {a[3:0] ^ 4'h5, a[3:0]};
    endfunction

    // load the counter: write-direction address plus word address, optional stop
    task automatic set_addr(input logic [AW-1:0] a, input bit with_stop, input string req);
        logic ack;
        bus_start();
        send_byte(abyte(1'b0, a[AW-1]), ack); chk({req, " addr ack"}, ack, 1'b1);
        send_byte(wbyte(a), ack);             chk({req, " word ack"}, ack, 1'b1);
        if (with_stop) bus_stop();
    endtask

    task automatic cur_read(input logic [7:0] exp, input string req);
        logic ack;
        logic [7:0] d;
        bus_start();
        send_byte(abyte(1'b1, 1'b0), ack); chk({req, " rd addr ack"}, ack, 1'b1);
        recv_byte(1'b0, d);
        bus_stop();
        chk({req, " cur read data"}, d, exp);
    endtask

    initial begin
        logic ack;
        logic [7:0] d;
        logic [AW-1:0] a;

        for (int i = 0; i < DEPTH; i++) model[i] = 8'((i * 29 + 7) ^ (i << 3));

        wq(4);
        rst_n = 1'b1;
        wq(1);
        chk("R1 released after reset", sda_pull, 1'b0);

        // R2 R10: preload every location with single-byte writes
        for (int i = 0; i < DEPTH; i++) begin
            a = AW'(i);
            set_addr(a, 1'b0, "R2");
            send_byte(model[i], ack); chk("R10 data ack", ack, 1'b1);
            bus_stop();
        end

        // R4 R6 R2: random read each address (read-direction MSB inverted, ignored), then current read
        for (int i = 0; i < DEPTH; i++) begin
            a = AW'(i);
            set_addr(a, 1'b0, "R4");
            bus_start();
            send_byte(abyte(1'b1, ~a[AW-1]), ack); chk("R2 rd addr ack", ack, 1'b1);
            recv_byte(1'b0, d);
            bus_stop();
            chk("R4 random read", d, model[i]);
            cur_read(model[(i + 1) % DEPTH], "R6");
        end

        // R5: set current address then two current reads
        set_addr(AW'(20), 1'b1, "R5");
        cur_read(model[20], "R5");
        cur_read(model[21], "R6");

        // R10: second data byte not acknowledged nor stored
        set_addr(AW'(3), 1'b0, "R10");
        send_byte(8'h5A, ack); chk("R10 first data ack", ack, 1'b1);
        send_byte(8'hC3, ack); chk("R10 extra byte nack", ack, 1'b0);
        bus_stop();
        model[3] = 8'h5A;
        set_addr(AW'(3), 1'b0, "R10");
        bus_start();
        send_byte(abyte(1'b1, 1'b0), ack);
        recv_byte(1'b1, d); chk("R10 stored byte", d, 8'h5A);
        recv_byte(1'b0, d); chk("R10 next untouched", d, model[4]);
        bus_stop();

        // R6: counter one past the last write
        set_addr(AW'(7), 1'b0, "R6");
        send_byte(model[7], ack);
        bus_stop();
        cur_read(model[8], "R6 after write");

        // R7 R8: sequential read across the wrap
        set_addr(AW'(28), 1'b0, "R8");
        bus_start();
        send_byte(abyte(1'b1, 1'b0), ack);
        for (int i = 0; i < 40; i++) begin
            recv_byte(i != 39, d);
            chk("R7 R8 sequential wrap", d, model[(28 + i) % DEPTH]);
        end
        bus_stop();

        // R9: release after master nack
        cur_read(model[(28 + 40) % DEPTH], "R9");
        wq(2);
        chk("R9 released after nack", sda_pull, 1'b0);

        // R3: mismatching select bits and device code ignored until next start
        set_addr(AW'(5), 1'b1, "R3");
        bus_start();
        send_byte({4'b1010, ~SEL, 1'b0, 1'b0}, ack); chk("R3 bad select nack", ack, 1'b0);
        send_byte(8'h09, ack);                       chk("R3 word ignored", ack, 1'b0);
        send_byte(8'hFF, ack);                       chk("R3 data ignored", ack, 1'b0);
        bus_stop();
        bus_start();
        send_byte({4'b1011, SEL, 1'b0, 1'b1}, ack);  chk("R3 bad code nack", ack, 1'b0);
        bus_stop();
        cur_read(model[5], "R3 counter unchanged");
        set_addr(AW'(9), 1'b0, "R3");
        bus_start();
        send_byte(abyte(1'b1, 1'b0), ack);
        recv_byte(1'b0, d); bus_stop();
        chk("R3 memory unchanged", d, model[9]);

        // R9: clocking after stop without a start is ignored
        scl_m = 1'b0; wq(1);
        send_byte(abyte(1'b1, 1'b0), ack); chk("R9 standby no ack", ack, 1'b0);
        bus_stop();
        cur_read(model[10], "R9 counter kept");

        // R12: start inside a word byte restarts address reception
        set_addr(AW'(12), 1'b1, "R12");
        bus_start();
        send_byte(abyte(1'b0, 1'b1), ack);
        send_bits(8'hF0, 4);
        bus_start();
        send_byte(abyte(1'b1, 1'b0), ack); chk("R12 addr after restart", ack, 1'b1);
        recv_byte(1'b0, d); bus_stop();
        chk("R12 counter kept", d, model[12]);

        chk("R11 pull moved with SCL high", r11_viol, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_err++;
            $display("FAIL watchdog R1..all actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
            $finish;
        end
    end

endmodule